// File: doc/BRIEF.md
# Multi-Counter Match Timer Bank

This block holds eight extended timer channels, numbered 4 to 11 and reached through slots 0 to 7. Each channel has a counter, a match value and a control word. Channels in a group share one counter by default. Slots 0 to 3 share slot 0's counter. Slots 4 and 5 share slot 4's counter. Slots 6 and 7 share slot 6's counter. A channel can choose to compare against its own counter instead. Counting speed comes from an eight-entry rate table, and the rates arrive as tick-enable inputs, not as real clocks. When a channel's compare counter reaches its match value, the channel raises a status bit. It does so only if the matching enable bit is set. All status bits are ORed into one interrupt line.

Software reaches the bank through a simple register port. `addr[4:3]` selects the register kind: 0 = counter, 1 = match, 2 = control, 3 = misc. `addr[2:0]` selects the slot. The misc slots are: 0 = snapshot (read only), 1 = enable (bits [7:0], one per slot), 2 = status (read; writing a 1 clears that bit). Read data is combinational from `addr`. The `rdEn` input is only needed for a counter read that takes a snapshot.

The control word fields are: [2:0] rate selection, [3] clear the counter on match, [6] periodic, [7] use own counter, [8] force rate selection 0 (slots 4 to 7), [9] snapshot on read (slots 5 and 7).

Top module: `xtimer_bank`

## Requirements
- R1: After reset all counters, match values, control words, enable and status bits read zero, and `irq` is low.
- R2: A counter advances by one on each clock edge where the `rateTick` bit chosen by its stored rate selection is high. Selections 0 and 5 never advance it.
- R3: A channel with control bit 7 clear compares against its group owner's counter. The owners are slot 0 for slots 0 to 3, slot 4 for slots 4 and 5, and slot 6 for slots 6 and 7.
- R4: A channel with control bit 7 set compares against its own counter, and a shared counter does not move because of it.
- R5: A control write changes the channel's stored rate selection only when data bit 7 is set or the slot is a group owner (slots 0, 4 and 6).
- R6: Control writes keep bits [7:0] for slots 0 to 3 and bits [9:0] for slots 4 to 7.
- R7: For slots 4 to 7, a control write with bit 8 set stores rate selection 0, which stops the counter.
- R8: A match fires on the edge where the compare counter would step onto the match value. With control bit 3 set, that counter is loaded with zero instead.
- R9: With control bit 6 clear, a channel fires once and then stays silent until one of its own registers is written. With bit 6 set, it fires every time the count reaches the match value.
- R10: A match sets its status bit only when its enable bit is set, and `irq` is high whenever any status bit is set.
- R11: Writing the status register clears every bit written as 1. `irq` drops once no status bit is left set.
- R12: A counter read of slot 5 or slot 7 with `rdEn` high and control bit 9 set copies the current count of slot 4 or slot 6 into the snapshot register. Without bit 9 the snapshot keeps its value.
- R13: A counter write loads that counter at once, and later matches are judged from the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Read qualifier; only matters for snapshot-taking counter reads |
| addr | input | 5 | Register kind [4:3] and slot [2:0] |
| wrData | input | CNT_W | Write data |
| rateTick | input | 8 | One tick-enable per rate-table entry |
| rdData | output | CNT_W | Combinational read data for `addr` |
| irq | output | 1 | Combined interrupt, OR of the status bits |

## Verification
The in-RTL properties check on every cycle that:
- a stopped counter holds its value;
- a load lands exactly;
- a one-shot channel disarms after it fires;
- a clear-on-match zeroes the compare counter;
- a status bit only rises when it is enabled, and a full clear drops `irq`;
- a snapshot captures the partner count;
- the rate rules for non-owner and forced-zero control writes hold.

Only the bench scenarios can show the rest: which group counter each slot actually follows, the exact edge on which a match appears, the periodic re-fire after a reload, and that the control storage widths read back correctly.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  localparam int NCH     = 8;
  localparam int SLOT_W  = $clog2(NCH);
  localparam int CTRL_W  = 10;
  localparam int SEL_W   = 3;
  localparam int NRATE   = 1 << SEL_W;
  localparam int EXT_SEL = 5;
  localparam int B_CLR   = 3;
  localparam int B_PER   = 6;
  localparam int B_OWN   = 7;
  localparam int B_FORCE = 8;
  localparam int B_SNAP  = 9;
  localparam int WIDE_LO = 4;

  typedef struct packed {
    logic [NCH-1:0]    ldCnt;
    logic [NCH-1:0]    ldMatch;
    logic [NCH-1:0]    ldCtrl;
    logic              ldEn;
    logic              clrSts;
    logic              snapReq;
    logic [SLOT_W-1:0] snapSrc;
  } strobe_t;

  function automatic logic [SLOT_W-1:0] groupOwner(input logic [SLOT_W-1:0] s);
    if (s < SLOT_W'(WIDE_LO)) return '0;
    return {s[SLOT_W-1:1], 1'b0};
  endfunction

  function automatic logic [CTRL_W-1:0] ctrlMask(input int s);
    return (s < WIDE_LO) ? CTRL_W'(8'hFF) : {CTRL_W{1'b1}};
  endfunction
endpackage

// File: rtl/xtb_ctrl.sv
module xtb_ctrl
  import xtb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [4:0]                    addr,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [NCH-1:0][CNT_W-1:0]     cntQ,
  input  logic [NCH-1:0][CNT_W-1:0]     matchQ,
  input  logic [NCH-1:0]                stsQ,
  input  logic [CNT_W-1:0]              snapQ,
  output strobe_t                       stb,
  output logic [NCH-1:0][CTRL_W-1:0]    ctrlQ,
  output logic [NCH-1:0][SEL_W-1:0]     rateSel,
  output logic [NCH-1:0]                enQ,
  output logic [CNT_W-1:0]              rdData
);
  localparam logic [1:0] K_CNT = 2'd0, K_MATCH = 2'd1, K_CTRL = 2'd2, K_MISC = 2'd3;
  localparam logic [SLOT_W-1:0] M_SNAP = 0, M_EN = 1, M_STS = 2;

  logic [1:0]        kind;
  logic [SLOT_W-1:0] slot;
  assign kind = addr[4:3];
  assign slot = addr[SLOT_W-1:0];

  always_comb begin
    stb         = '0;
    stb.ldCnt   = (wrEn && kind == K_CNT)   ? (NCH'(1) << slot) : '0;
    stb.ldMatch = (wrEn && kind == K_MATCH) ? (NCH'(1) << slot) : '0;
    stb.ldCtrl  = (wrEn && kind == K_CTRL)  ? (NCH'(1) << slot) : '0;
    stb.ldEn    = wrEn && kind == K_MISC && slot == M_EN;
    stb.clrSts  = wrEn && kind == K_MISC && slot == M_STS;
    stb.snapReq = rdEn && kind == K_CNT && slot >= SLOT_W'(WIDE_LO) && slot[0]
                  && ctrlQ[slot][B_SNAP];
    stb.snapSrc = {slot[SLOT_W-1:1], 1'b0};
  end

  for (genvar s = 0; s < NCH; s++) begin : g_ch
    localparam logic [SLOT_W-1:0] SID = SLOT_W'(s);
    localparam bit OWNER = (groupOwner(SID) == SID);
    logic takeRate;
    assign takeRate = wrData[B_OWN] || OWNER;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[s]   <= '0;
        rateSel[s] <= '0;
      end else if (stb.ldCtrl[s]) begin
        ctrlQ[s] <= wrData[CTRL_W-1:0] & ctrlMask(s);
        if (takeRate)
          rateSel[s] <= (s >= WIDE_LO && wrData[B_FORCE]) ? '0 : wrData[SEL_W-1:0];
      end
    end

    p_rate_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
      stb.ldCtrl[s] && !wrData[B_OWN] && !OWNER |=> $stable(rateSel[s]));
    if (s >= WIDE_LO) begin : g_wide
      p_force_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
        stb.ldCtrl[s] && wrData[B_FORCE] && takeRate |=> rateSel[s] == '0);
    end else begin : g_narrow
      p_narrow_r6: assert property (@(posedge clk) disable iff (!rstN)
        stb.ldCtrl[s] |=> ctrlQ[s][CTRL_W-1:8] == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        enQ <= '0;
    else if (stb.ldEn) enQ <= wrData[NCH-1:0];
  end

  always_comb begin
    rdData = '0;
    unique case (kind)
      K_CNT:   rdData = cntQ[slot];
      K_MATCH: rdData = matchQ[slot];
      K_CTRL:  rdData = CNT_W'(ctrlQ[slot]);
      default: begin
        if (slot == M_SNAP)     rdData = snapQ;
        else if (slot == M_EN)  rdData = CNT_W'(enQ);
        else if (slot == M_STS) rdData = CNT_W'(stsQ);
      end
    endcase
  end
endmodule

// File: rtl/xtb_datapath.sv
module xtb_datapath
  import xtb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [NCH-1:0][CTRL_W-1:0]    ctrlQ,
  input  logic [NCH-1:0][SEL_W-1:0]     rateSel,
  input  logic [NCH-1:0]                enQ,
  input  logic [NRATE-1:0]              rateTick,
  output logic [NCH-1:0][CNT_W-1:0]     cntQ,
  output logic [NCH-1:0][CNT_W-1:0]     matchQ,
  output logic [NCH-1:0]                stsQ,
  output logic [CNT_W-1:0]              snapQ,
  output logic                          irq
);
  logic [NCH-1:0]             tick, fire, clrHit, armed, anyLd;
  logic [NCH-1:0][SLOT_W-1:0] srcIdx;
  logic [NCH-1:0]             clrMask;

  always_comb begin
    for (int j = 0; j < NCH; j++) begin
      tick[j] = (rateSel[j] != '0) && (rateSel[j] != SEL_W'(EXT_SEL)) && rateTick[rateSel[j]];
      srcIdx[j] = ctrlQ[j][B_OWN] ? SLOT_W'(j) : groupOwner(SLOT_W'(j));
      anyLd[j]  = stb.ldCnt[j] | stb.ldMatch[j] | stb.ldCtrl[j];
    end
    clrHit = '0;
    for (int i = 0; i < NCH; i++) begin
      fire[i] = armed[i] && tick[srcIdx[i]] && !stb.ldCnt[srcIdx[i]]
                && ((cntQ[srcIdx[i]] + CNT_W'(1)) == matchQ[i]);
      if (fire[i] && ctrlQ[i][B_CLR]) clrHit[srcIdx[i]] = 1'b1;
    end
  end

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[j]   <= '0;
        matchQ[j] <= '0;
        armed[j]  <= 1'b0;
      end else begin
        if (stb.ldCnt[j])     cntQ[j] <= wrData;
        else if (clrHit[j])   cntQ[j] <= '0;
        else if (tick[j])     cntQ[j] <= cntQ[j] + CNT_W'(1);
        if (stb.ldMatch[j])   matchQ[j] <= wrData;
        if (anyLd[j])         armed[j] <= 1'b1;
        else if (fire[j] && !ctrlQ[j][B_PER]) armed[j] <= 1'b0;
      end
    end

    p_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
      (rateSel[j] == '0) && !stb.ldCnt[j] |=> $stable(cntQ[j]));
    p_load_r13: assert property (@(posedge clk) disable iff (!rstN)
      stb.ldCnt[j] |=> cntQ[j] == $past(wrData));
    p_oneshot_r9: assert property (@(posedge clk) disable iff (!rstN)
      fire[j] && !ctrlQ[j][B_PER] && !anyLd[j] |=> !armed[j]);
    p_clear_on_match_r8: assert property (@(posedge clk) disable iff (!rstN)
      fire[j] && ctrlQ[j][B_CLR] && !stb.ldCnt[srcIdx[j]] && !stb.ldCtrl[j]
      |=> cntQ[srcIdx[j]] == '0);
    p_enable_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stsQ[j]) |-> $past(enQ[j]));
  end

  assign clrMask = stb.clrSts ? wrData[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ  <= '0;
      snapQ <= '0;
    end else begin
      stsQ <= (stsQ & ~clrMask) | (fire & enQ);
      if (stb.snapReq) snapQ <= cntQ[stb.snapSrc];
    end
  end

  assign irq = |stsQ;

  p_full_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrSts && ((stsQ & ~wrData[NCH-1:0]) == '0) && ((fire & enQ) == '0) |=> !irq);
  p_snapshot_r12: assert property (@(posedge clk) disable iff (!rstN)
    stb.snapReq |=> snapQ == $past(cntQ[stb.snapSrc]));
endmodule

// File: rtl/xtimer_bank.sv
module xtimer_bank
  import xtb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [4:0]           addr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [NRATE-1:0]     rateTick,
  output logic [CNT_W-1:0]     rdData,
  output logic                 irq
);
  strobe_t                     stb;
  logic [NCH-1:0][CTRL_W-1:0]  ctrlQ;
  logic [NCH-1:0][SEL_W-1:0]   rateSel;
  logic [NCH-1:0]              enQ, stsQ;
  logic [NCH-1:0][CNT_W-1:0]   cntQ, matchQ;
  logic [CNT_W-1:0]            snapQ;

  xtb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .cntQ(cntQ), .matchQ(matchQ), .stsQ(stsQ), .snapQ(snapQ),
    .stb(stb), .ctrlQ(ctrlQ), .rateSel(rateSel), .enQ(enQ), .rdData(rdData));

  xtb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .ctrlQ(ctrlQ),
    .rateSel(rateSel), .enQ(enQ), .rateTick(rateTick),
    .cntQ(cntQ), .matchQ(matchQ), .stsQ(stsQ), .snapQ(snapQ), .irq(irq));
endmodule

// File: tb/sim_xtimer_bank.sv
module sim_xtimer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rateTick = '0;
  logic [31:0] rdData;
  logic        irq;
  int nChecks = 0, nErr = 0;
  bit done = 0;

  localparam logic [4:0] A_SNAP = 5'd24, A_EN = 5'd25, A_STS = 5'd26;

  xtimer_bank u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
                  .wrData(wrData), .rateTick(rateTick), .rdData(rdData), .irq(irq));

  always #5 clk = ~clk;

  function automatic logic [4:0] aCnt(int s);   return 5'(s);      endfunction
  function automatic logic [4:0] aMatch(int s); return 5'(8 + s);  endfunction
  function automatic logic [4:0] aCtrl(int s);  return 5'(16 + s); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(string tag, logic [4:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; rdEn = 1'b1; #1;
    check(tag, rdData, exp);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic run(int n);
    @(negedge clk); rateTick = 8'hFF;
    repeat (n) @(posedge clk);
    @(negedge clk); rateTick = 8'h00;
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  endtask

  // {write, addr, data, expected read}
  localparam int NV = 12;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 5'd16, 32'h0000_03FF, 32'h0},
    {1'b0, 5'd16, 32'h0,         32'h0000_00FF},  // R6 narrow slot keeps 8 bits
    {1'b1, 5'd20, 32'h0000_0FFF, 32'h0},
    {1'b0, 5'd20, 32'h0,         32'h0000_03FF},  // R6 wide slot keeps 10 bits
    {1'b1, 5'd11, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 5'd11, 32'h0,         32'hDEAD_BEEF},
    {1'b1, 5'd2,  32'h0000_1234, 32'h0},
    {1'b0, 5'd2,  32'h0,         32'h0000_1234},  // R13 counter load
    {1'b1, 5'd25, 32'h0000_01FF, 32'h0},
    {1'b0, 5'd25, 32'h0,         32'h0000_00FF},
    {1'b1, 5'd16, 32'h0,         32'h0},
    {1'b1, 5'd20, 32'h0,         32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd("R1 counter", aCnt(0), 0);
    rd("R1 match", aMatch(6), 0);
    rd("R1 control", aCtrl(3), 0);
    rd("R1 status", A_STS, 0);
    rd("R1 enable", A_EN, 0);
    check("R1 irq", irq, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][69]) wr(VEC[v][68:64], VEC[v][63:32]);
      else rd("R6/R13 table", VEC[v][68:64], VEC[v][31:0]);
    end
    wr(aMatch(3), 0);

    // R3 R13 R10: slot1 follows slot0's counter
    wr(aCnt(0), 0); wr(aMatch(1), 5); wr(aCtrl(1), 0); wr(aCtrl(0), 1);
    run(4);
    rd("R2 count", aCnt(0), 4);
    rd("R8 no early match", A_STS, 0);
    run(1);
    rd("R2 count", aCnt(0), 5);
    rd("R3 shared match", A_STS, 32'h02);
    check("R10 irq", irq, 1);
    wr(A_STS, 32'h02);
    rd("R11 cleared", A_STS, 0);
    check("R11 irq low", irq, 0);

    // R9 one-shot stays silent
    wr(aCnt(0), 0); run(6);
    rd("R9 one-shot", A_STS, 0);
    // R9 periodic re-fire
    wr(aCtrl(1), 32'h40); wr(aCnt(0), 0); run(5);
    rd("R9 periodic first", A_STS, 32'h02);
    wr(A_STS, 32'h02); wr(aCnt(0), 0); run(5);
    rd("R9 periodic again", A_STS, 32'h02);

    // R8 clear-on-match
    wr(aCtrl(0), 32'h09); wr(aMatch(0), 3); wr(aCnt(0), 0);
    run(3);
    rd("R8 counter zeroed", aCnt(0), 0);
    rd("R8 status", A_STS, 32'h03);
    run(2);
    rd("R8 restart", aCnt(0), 2);
    wr(A_STS, 32'h01);
    rd("R11 partial clear", A_STS, 32'h02);
    check("R11 irq still high", irq, 1);
    wr(A_STS, 32'h02);
    check("R11 irq drops", irq, 0);
    wr(aCtrl(0), 0);

    // R4 own counter
    wr(aCtrl(2), 32'h82); wr(aMatch(2), 3); wr(aCnt(2), 0);
    run(3);
    rd("R4 own count", aCnt(2), 3);
    rd("R4 own match", A_STS, 32'h04);
    rd("R4 shared untouched", aCnt(0), 2);
    wr(A_STS, 32'h04);

    // R5 non-owner without bit 7 keeps rate
    wr(aCnt(3), 0); wr(aCtrl(3), 32'h01); run(4);
    rd("R5 rate ignored", aCnt(3), 0);
    rd("R5 control stored", aCtrl(3), 32'h01);

    // R3 second group
    wr(aCtrl(4), 32'h01); wr(aCnt(4), 0); wr(aMatch(5), 2); wr(aCtrl(5), 0);
    run(2);
    rd("R3 group two", A_STS, 32'h20);
    rd("R2 owner count", aCnt(4), 2);
    wr(A_STS, 32'h20);

    // R2 selection 5 stopped, R7 force
    wr(aCtrl(4), 32'h05); run(3);
    rd("R2 external stopped", aCnt(4), 2);
    wr(aCtrl(4), 32'h101); run(3);
    rd("R7 forced stop", aCnt(4), 2);
    rd("R6 wide control", aCtrl(4), 32'h101);
    wr(aCtrl(4), 32'h03);
    @(negedge clk); rateTick = 8'h02; repeat (3) @(negedge clk); rateTick = 8'h00;
    rd("R2 wrong tick", aCnt(4), 2);
    @(negedge clk); rateTick = 8'h08; repeat (3) @(negedge clk); rateTick = 8'h00;
    rd("R2 chosen tick", aCnt(4), 5);

    // R10 disabled channel, R12 snapshot
    wr(A_EN, 32'h7F);
    wr(aCtrl(6), 32'h01); wr(aCnt(6), 32'h100);
    wr(aMatch(7), 32'h104); wr(aCtrl(7), 32'h200);
    run(7);
    rd("R10 disabled no status", A_STS, 0);
    check("R10 irq low", irq, 0);
    rd("R12 partner read", aCnt(7), 0);
    rd("R12 snapshot", A_SNAP, 32'h107);
    wr(aCtrl(7), 0); run(1);
    rd("R12 no-snap read", aCnt(7), 0);
    rd("R12 snapshot kept", A_SNAP, 32'h107);
    rd("R2 partner count", aCnt(6), 32'h108);

    finishRun();
  end
endmodule